// File: doc/BRIEF.md
# Masked Fault Summary Aggregator

This block collects fault state from several hardware units and condenses it into one summary bit per unit inside a 32-bit status word. Each unit owns five 64-bit registers: a fault register, a mask register, two action-select registers (A and B) and a mode register. A fault bit counts toward the unit's summary only when it is set and unmasked and its action code selects host reporting (A=1, B=0). The unit must also have reporting switched on in its mode register. The summary bits are recomputed every cycle, so they fall as well as rise.

Fault bits come in two ways. Hardware can set them through a per-unit set vector, and they then stay set. A host can also overwrite them through a simple register write port. The block keeps a mirror copy of the status word one cycle behind it. Whenever the two differ in a bit that the status-mask register does not hide, the block raises a host-attention bit in its interrupt presentation output. That bit is high for one cycle for each change.

Top module: `fault_summary_agg`

## Requirements
- R1: After reset every register is zero, and `status_o`, `intr_o` and every register read return zero.
- R2: Unit u's summary is high when at least one bit position has fault=1, mask=0, action A=1 and action B=0, and its mode bit 13 is 1. The summary appears in `status_o` one cycle after the register write that causes it.
- R3: A fault bit whose action code (A,B) is 00, 01 or 11 does not make the summary high.
- R4: Setting a fault bit's mask bit removes only that bit from the summary. Unmasked reporting bits still report.
- R5: When mode bit 13 of a unit is 0, its summary is low, whatever the other mode bits hold.
- R6: Unit u drives status bit 7+u. For 8 units this uses bits 7 to 14, and all other status bits are 0.
- R7: A summary bit is not sticky. It falls one cycle after the write that removes the last reporting fault.
- R8: A bit of `fault_set_i` that is high for one cycle sets the matching fault bit, and the bit stays set until the host writes that fault register.
- R9: The host address is {unit[2:0], sel[2:0]}. The sel codes are 0 fault, 1 mask, 2 action A, 3 action B, 4 mode, 5 status mask (global), 6 status word and 7 mirror. Reads are combinational, and writes take effect at the clock edge.
- R10: The mirror holds the value the status word had one cycle earlier.
- R11: Bit 2 of `intr_o` is high for exactly one cycle after each change of an unmasked status bit. This holds for both rising and falling changes.
- R12: A change only in status bits whose status-mask bit is 1 does not raise bit 2 of `intr_o`.
- R13: All `intr_o` bits other than bit 2 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_set_i | input | NUM_UNITS*FIR_W | Hardware fault set bits, unit u in slice [u*64 +: 64] |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write address {unit, sel} |
| wr_data_i | input | FIR_W | Host write data |
| rd_addr_i | input | ADDR_W | Host read address {unit, sel} |
| rd_data_o | output | FIR_W | Host read data, combinational |
| status_o | output | STAT_W | Status word with the per-unit summaries |
| intr_o | output | INTR_W | Interrupt presentation, bit 2 is host attention |

## Verification
On every cycle the assertions check four things. Each status bit tracks its unit's summary of the previous cycle. A unit with mode reporting off never shows a summary. The mirror lags the status word by exactly one cycle, and the attention bit equals the unmasked difference between them. The assertions also check that bits outside the summary field and outside the attention position stay zero. Only the bench scenarios show which action codes report and that masking is selective. They also cover hardware set bits staying sticky until overwritten, the address map on readback, and attention being held back by the status mask in both directions.

// File: rtl/fsa_pkg.sv
// Shared definitions for the fault summary aggregator.
// Assumes a fixed 3-bit register-select field at the bottom of each host address.
package fsa_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_FAULT = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_ACTA  = 3'd2,
        SEL_ACTB  = 3'd3,
        SEL_MODE  = 3'd4,
        SEL_SMASK = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_MIRR  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/fsa_unit.sv
// One unit's register set: fault, mask, action A, action B and mode.
// It produces the unit's summary bit: some fault is unmasked with action code A=1,B=0,
// and the reporting bit of the mode register is set.
// Assumes wr_en is already qualified by the unit index.
module fsa_unit
    import fsa_pkg::*;
#(
    parameter int FIR_W    = 64,
    parameter int MODE_BIT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [FIR_W-1:0] wr_data,
    input  logic [FIR_W-1:0] hw_set,
    input  reg_sel_e         rd_sel,
    output logic [FIR_W-1:0] rd_data,
    output logic             summary_o,
    output logic             mode_en_o
);
    logic [FIR_W-1:0] fault_q, mask_q, acta_q, actb_q, mode_q;
    logic [FIR_W-1:0] report_vec;
    logic             fault_wr;

    assign fault_wr = wr_en && (wr_sel == SEL_FAULT);

    // Fault register: a host write replaces the value, and hardware set bits OR in and stick.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= (fault_wr ? wr_data : fault_q) | hw_set;
    end

    // Host-written mask, action and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            acta_q <= '0;
            actb_q <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MASK: mask_q <= wr_data;
                SEL_ACTA: acta_q <= wr_data;
                SEL_ACTB: actb_q <= wr_data;
                SEL_MODE: mode_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Per-bit reporting qualification and the unit summary.
    always_comb begin
        report_vec = fault_q & ~mask_q & acta_q & ~actb_q;
        mode_en_o  = mode_q[MODE_BIT];
        summary_o  = mode_en_o && (|report_vec);
    end

    // Read-back of this unit's registers.
    always_comb begin
        case (rd_sel)
            SEL_FAULT: rd_data = fault_q;
            SEL_MASK:  rd_data = mask_q;
            SEL_ACTA:  rd_data = acta_q;
            SEL_ACTB:  rd_data = actb_q;
            SEL_MODE:  rd_data = mode_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/fsa_status.sv
// Status word, its one-cycle mirror and the change-detect attention.
// Assumes SUM_BASE + NUM_UNITS <= STAT_W and ATTN_BIT < INTR_W.
module fsa_status #(
    parameter int NUM_UNITS = 8,
    parameter int STAT_W    = 32,
    parameter int SUM_BASE  = 7,
    parameter int INTR_W    = 32,
    parameter int ATTN_BIT  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] sum_vec,
    input  logic [STAT_W-1:0]    stat_mask,
    output logic [STAT_W-1:0]    status_q,
    output logic [STAT_W-1:0]    mirror_q,
    output logic [INTR_W-1:0]    intr_o
);
    logic [STAT_W-1:0] status_next;

    // Place each unit summary at its status bit, and tie the other bits low.
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b >= SUM_BASE && b < SUM_BASE + NUM_UNITS) begin : g_sum
            assign status_next[b] = sum_vec[b-SUM_BASE];
        end else begin : g_zero
            assign status_next[b] = 1'b0;
        end
    end

    // Status recomputed every cycle, and the mirror trails it by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mirror_q <= '0;
        end else begin
            status_q <= status_next;
            mirror_q <= status_q;
        end
    end

    // Attention when any unmasked status bit differs from its mirror.
    always_comb begin
        intr_o           = '0;
        intr_o[ATTN_BIT] = |((status_q ^ mirror_q) & ~stat_mask);
    end
endmodule

// File: rtl/fault_summary_agg.sv
// Top level: NUM_UNITS fault register sets, a global status-mask register,
// the host access decode and the status/attention logic.
// Assumes FIR_W >= STAT_W so the status mask fits in one write.
module fault_summary_agg
    import fsa_pkg::*;
#(
    parameter  int NUM_UNITS = 8,
    parameter  int FIR_W     = 64,
    parameter  int STAT_W    = 32,
    parameter  int INTR_W    = 32,
    parameter  int SUM_BASE  = 7,
    parameter  int MODE_BIT  = 13,
    parameter  int ATTN_BIT  = 2,
    localparam int UNIT_AW   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int ADDR_W    = UNIT_AW + SEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_UNITS*FIR_W-1:0] fault_set_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [FIR_W-1:0]           wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [FIR_W-1:0]           rd_data_o,
    output logic [STAT_W-1:0]          status_o,
    output logic [INTR_W-1:0]          intr_o
);
    logic [UNIT_AW-1:0]   wr_unit, rd_unit;
    reg_sel_e             wr_sel, rd_sel;
    logic [NUM_UNITS-1:0] sum_vec, mode_vec;
    logic [FIR_W-1:0]     unit_rd [NUM_UNITS];
    logic [STAT_W-1:0]    stat_mask_q, status_q, mirror_q;

    assign wr_unit = wr_addr_i[ADDR_W-1:SEL_W];
    assign wr_sel  = reg_sel_e'(wr_addr_i[SEL_W-1:0]);
    assign rd_unit = rd_addr_i[ADDR_W-1:SEL_W];
    assign rd_sel  = reg_sel_e'(rd_addr_i[SEL_W-1:0]);

    // One register set per unit.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic unit_wr;
        assign unit_wr = wr_en_i && (wr_unit == UNIT_AW'(u));
        fsa_unit #(.FIR_W(FIR_W), .MODE_BIT(MODE_BIT)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (unit_wr),
            .wr_sel    (wr_sel),
            .wr_data   (wr_data_i),
            .hw_set    (fault_set_i[u*FIR_W +: FIR_W]),
            .rd_sel    (rd_sel),
            .rd_data   (unit_rd[u]),
            .summary_o (sum_vec[u]),
            .mode_en_o (mode_vec[u])
        );
    end

    // Global status-mask register; a write with any unit index reaches it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                stat_mask_q <= '0;
        else if (wr_en_i && wr_sel == SEL_SMASK)   stat_mask_q <= wr_data_i[STAT_W-1:0];
    end

    fsa_status #(
        .NUM_UNITS (NUM_UNITS),
        .STAT_W    (STAT_W),
        .SUM_BASE  (SUM_BASE),
        .INTR_W    (INTR_W),
        .ATTN_BIT  (ATTN_BIT)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .sum_vec   (sum_vec),
        .stat_mask (stat_mask_q),
        .status_q  (status_q),
        .mirror_q  (mirror_q),
        .intr_o    (intr_o)
    );

    assign status_o = status_q;

    // Host read mux: global registers first, then the addressed unit.
    always_comb begin
        rd_data_o = '0;
        case (rd_sel)
            SEL_SMASK: rd_data_o = FIR_W'(stat_mask_q);
            SEL_STAT:  rd_data_o = FIR_W'(status_q);
            SEL_MIRR:  rd_data_o = FIR_W'(mirror_q);
            default: begin
                if ({1'b0, rd_unit} < (UNIT_AW+1)'(NUM_UNITS))
                    rd_data_o = unit_rd[rd_unit];
            end
        endcase
    end
endmodule

// File: rtl/fsa_checker.sv
// Cycle-by-cycle properties of the aggregator, bound to the top module.
// Assumes a synchronous reset that is held for at least two clock edges.
module fsa_checker #(
    parameter int NUM_UNITS = 8,
    parameter int STAT_W    = 32,
    parameter int SUM_BASE  = 7,
    parameter int INTR_W    = 32,
    parameter int ATTN_BIT  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [STAT_W-1:0]    status,
    input logic [STAT_W-1:0]    mirror,
    input logic [STAT_W-1:0]    smask,
    input logic [INTR_W-1:0]    intr,
    input logic [NUM_UNITS-1:0] sums,
    input logic [NUM_UNITS-1:0] mode_en
);
    localparam logic [STAT_W-1:0] FIELD = ((STAT_W'(1) << NUM_UNITS) - STAT_W'(1)) << SUM_BASE;
    localparam logic [INTR_W-1:0] ATTN  = INTR_W'(1) << ATTN_BIT;

    // R10: mirror is the previous status word
    p_mirror_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mirror == $past(status));

    // R11 / R12: attention equals an unmasked change since the previous cycle
    p_attn_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        intr[ATTN_BIT] == (|((status ^ $past(status)) & ~smask)));

    // R13: only the attention position of the interrupt output is used
    p_intr_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (intr & ~ATTN) == '0);

    // R6: nothing outside the summary field is set
    p_field_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~FIELD) == '0);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        // R2: status bit follows its unit summary one cycle later
        p_summary_r2: assert property (@(posedge clk) disable iff (!rst_n)
            status[SUM_BASE+u] == $past(sums[u]));
        // R5: reporting disabled forces the status bit low
        p_mode_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(mode_en[u]) |-> !status[SUM_BASE+u]);
    end
endmodule

bind fault_summary_agg fsa_checker #(
    .NUM_UNITS (NUM_UNITS),
    .STAT_W    (STAT_W),
    .SUM_BASE  (SUM_BASE),
    .INTR_W    (INTR_W),
    .ATTN_BIT  (ATTN_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status_o),
    .mirror  (mirror_q),
    .smask   (stat_mask_q),
    .intr    (intr_o),
    .sums    (sum_vec),
    .mode_en (mode_vec)
);

// File: tb/tb_fault_summary_agg.sv
// Directed bench: one task per scenario; inputs driven and outputs sampled at the falling edge.
module tb_fault_summary_agg;
    localparam int NU = 8;
    localparam int FW = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NU*FW-1:0] fault_set = '0;
    logic           wr_en = 1'b0;
    logic [5:0]     wr_addr = '0;
    logic [63:0]    wr_data = '0;
    logic [5:0]     rd_addr = '0;
    logic [63:0]    rd_data;
    logic [31:0]    status;
    logic [31:0]    intr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fault_summary_agg dut (
        .clk(clk), .rst_n(rst_n), .fault_set_i(fault_set),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .status_o(status), .intr_o(intr)
    );

    function automatic logic [5:0] ad(input int unit, input int sel);
        return {unit[2:0], sel[2:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R1 status", 64'(status), 64'h0);
        chk("R1 intr", 64'(intr), 64'h0);
        rd(ad(2, 4), v);
        chk("R1 mode read", v, 64'h0);
        rd(ad(5, 0), v);
        chk("R1 fault read", v, 64'h0);
    endtask

    task automatic t_report();
        logic [63:0] v;
        wr(ad(3, 4), 64'h1 << 13);
        wr(ad(3, 2), 64'h1 << 5);
        wr(ad(3, 0), 64'h1 << 5);
        settle();
        chk("R2 summary up", 64'(status), 64'h400);
        chk("R11 attn rise", 64'(intr), 64'h4);
        rd(ad(0, 7), v);
        chk("R10 mirror old", v, 64'h0);
        settle();
        chk("R11 attn one cycle", 64'(intr), 64'h0);
        rd(ad(0, 7), v);
        chk("R10 mirror new", v, 64'h400);
    endtask

    task automatic t_codes();
        wr(ad(3, 3), 64'h1 << 5);
        settle();
        chk("R3 code 11", 64'(status), 64'h0);
        chk("R7 falls", 64'(status), 64'h0);
        wr(ad(3, 2), 64'h0);
        settle();
        chk("R3 code 01", 64'(status), 64'h0);
        wr(ad(3, 3), 64'h0);
        settle();
        chk("R3 code 00", 64'(status), 64'h0);
        wr(ad(3, 2), 64'h1 << 5);
        settle();
        chk("R2 code 10 again", 64'(status), 64'h400);
        settle();
    endtask

    task automatic t_mask();
        wr(ad(3, 1), 64'h1 << 5);
        settle();
        chk("R4 masked", 64'(status), 64'h0);
        chk("R11 attn fall", 64'(intr), 64'h4);
        settle();
        chk("R11 attn clears", 64'(intr), 64'h0);
        wr(ad(3, 2), (64'h1 << 5) | (64'h1 << 40));
        wr(ad(3, 0), (64'h1 << 5) | (64'h1 << 40));
        settle();
        chk("R4 other bit reports", 64'(status), 64'h400);
        wr(ad(3, 1), 64'h0);
        wr(ad(3, 0), 64'h1 << 5);
        wr(ad(3, 2), 64'h1 << 5);
        settle();
        chk("R4 unmasked", 64'(status), 64'h400);
        settle();
    endtask

    task automatic t_mode();
        wr(ad(3, 4), 64'h0);
        settle();
        chk("R5 mode off", 64'(status), 64'h0);
        wr(ad(3, 4), ~(64'h1 << 13));
        settle();
        chk("R5 other mode bits", 64'(status), 64'h0);
        wr(ad(3, 4), 64'h1 << 13);
        settle();
        chk("R5 mode on", 64'(status), 64'h400);
        settle();
    endtask

    task automatic t_statmask();
        wr(ad(1, 5), 64'h1 << 10);
        wr(ad(3, 4), 64'h0);
        settle();
        chk("R12 status changed", 64'(status), 64'h0);
        chk("R12 no attn", 64'(intr), 64'h0);
        settle();
        chk("R12 no attn later", 64'(intr), 64'h0);
        wr(ad(3, 4), 64'h1 << 13);
        settle();
        chk("R12 no attn on rise", 64'(intr), 64'h0);
        wr(ad(0, 5), 64'h0);
        settle();
    endtask

    task automatic t_hwset();
        logic [63:0] v;
        wr(ad(0, 4), 64'h1 << 13);
        wr(ad(0, 2), 64'h1 << 63);
        @(negedge clk);
        fault_set[63] = 1'b1;
        @(negedge clk);
        fault_set[63] = 1'b0;
        settle();
        chk("R8 hw set reports", 64'(status), 64'h480);
        rd(ad(0, 0), v);
        chk("R8 sticky fault", v, 64'h1 << 63);
        settle();
        rd(ad(0, 0), v);
        chk("R8 still set", v, 64'h1 << 63);
        wr(ad(0, 0), 64'h0);
        settle();
        rd(ad(0, 0), v);
        chk("R8 host clear", v, 64'h0);
        chk("R8 summary cleared", 64'(status), 64'h400);
        settle();
    endtask

    task automatic t_all();
        for (int u = 0; u < NU; u++) begin
            wr(ad(u, 4), 64'h1 << 13);
            wr(ad(u, 2), 64'h1 << u);
            wr(ad(u, 0), 64'h1 << u);
        end
        settle();
        chk("R6 all units", 64'(status), 64'h7F80);
        settle();
        chk("R13 intr quiet", 64'(intr), 64'h0);
    endtask

    task automatic t_readback();
        logic [63:0] v;
        wr(ad(6, 1), 64'hDEAD_BEEF_0123_4567);
        rd(ad(6, 1), v);
        chk("R9 mask read", v, 64'hDEAD_BEEF_0123_4567);
        rd(ad(5, 1), v);
        chk("R9 unit select", v, 64'h0);
        wr(ad(6, 1), 64'h0);
        wr(ad(2, 5), 64'h0000_0000_8000_0001);
        rd(ad(7, 5), v);
        chk("R9 smask read", v, 64'h8000_0001);
        rd(ad(4, 6), v);
        chk("R9 status read", v, 64'h7F80);
        rd(ad(1, 7), v);
        chk("R9 mirror read", v, 64'h7F80);
        rd(ad(4, 3), v);
        chk("R9 actb read", v, 64'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_report();
        t_codes();
        t_mask();
        t_mode();
        t_statmask();
        t_hwset();
        t_all();
        t_readback();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule